// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Sequencer

This block sits between an internal requester and an external asynchronous parallel ROM that has a page read feature. The requester hands over a starting location, a burst length and a width choice in a single valid/ready transfer. The sequencer then drives the chip select, the output-enable pin, the address pins and the width-select pin. It waits a cycle count derived from the ROM's access times and returns each captured item on a one-cycle strobe.

The first item of a burst always gets the slow random-access wait. Items that follow inside the same page get the short page wait. When the next location falls on a new page, the sequencer goes back to the slow wait. In 8-bit operation the ROM's top data pin becomes an input that carries the lowest address bit. The controller drives it, and only the low data byte is kept.

After reset the chip select stays idle for a minimum settling time before any read starts. After each burst the ROM is deselected for a bus-release gap. All timings are given in nanoseconds and converted to cycles from the clock period, rounding up.

Top module: `pagerom_rd_ctrl`

## Requirements
- R1: After reset is released, `rom_ce_n` stays 1 and `req_ready` stays 0 for at least ceil(T_PWRUP_NS/CLK_NS) cycles before the first read.
- R2: `req_ready` is 1 only when no burst is in progress. A request is taken on a clock edge with `req_valid` and `req_ready` both 1, and `rom_ce_n` is 0 from the next cycle.
- R3: The first item of every burst appears on `rd_valid` ACC+1 cycles after the acceptance edge, where ACC = ceil(T_ACC_NS/CLK_NS). The extra cycle allows for input synchronisation.
- R4: Each subsequent item whose location stays on the same page appears PAGE+1 cycles after the previous item, where PAGE = ceil(T_PAGE_NS/CLK_NS).
- R5: An item whose location is the first of a page (its low page bits are all zero) waits a full ACC+1 cycles.
- R6: With `req_byte_mode`=0, the location is a word index. `rom_addr` = loc[ADDR_W-1:0], `rom_wide` = 1 and `rom_lsb_oe` = 0. `rd_data` carries all 16 `rom_dq` bits. A page spans 2^PAGE_LOG2 words.
- R7: With `req_byte_mode`=1, the location is a byte index. `rom_addr` = loc[ADDR_W:1], `rom_lsb_out` = loc[0], `rom_lsb_oe` = 1 and `rom_wide` = 0. `rd_data` = {8'h00, rom_dq[7:0]}, so pins 8 to 14 have no effect. A page spans 2^(PAGE_LOG2+1) bytes.
- R8: A burst returns `req_len_m1`+1 items in consecutive locations, unless R9 applies. `rd_done` is 1 together with the `rd_valid` of the last item only.
- R9: A burst that would run past the last location stops after that location. `rd_err` is then 1 with `rd_done`; otherwise `rd_err` stays 0.
- R10: After a burst, `rom_ce_n` stays 1 for at least ceil(T_FLOAT_NS/CLK_NS) cycles before the next burst selects the ROM.
- R11: `rom_oe` is at its active level while the ROM is selected and inactive otherwise. Active-low, active-high or unused (held 0) is chosen by `OE_MODE`.
- R12: `rom_wide` does not change while `rom_ce_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Controller can take a request |
| req_byte_mode | input | 1 | 1 = 8-bit items, 0 = 16-bit items |
| req_loc | input | ADDR_W+1 | Starting location (byte or word index) |
| req_len_m1 | input | LEN_W | Item count minus one |
| rd_valid | output | 1 | One returned item |
| rd_data | output | 16 | Returned item |
| rd_done | output | 1 | Last item of the burst |
| rd_err | output | 1 | Burst cut short at the end of the address space |
| rom_ce_n | output | 1 | ROM chip select, active low |
| rom_oe | output | 1 | ROM output-enable pin |
| rom_wide | output | 1 | ROM width select, 1 = 16-bit |
| rom_addr | output | ADDR_W | ROM address pins |
| rom_lsb_out | output | 1 | Lowest byte-address bit toward the shared top data pin |
| rom_lsb_oe | output | 1 | Drive enable for the shared top data pin |
| rom_dq | input | 16 | ROM data pins |

## Verification
The bench builds the block with ADDR_W=5, which gives 32 words or 64 bytes, and PAGE_LOG2=2. It uses the default nanosecond timings on a 5 ns clock, so the waits are 24, 5, 4 and 40 cycles. OE_MODE is set to active-high. With this small space, full sweeps read every word and every byte, and they start from every in-page offset. Both end-of-space cutoffs are also in reach, in each width. The ROM model in the bench returns a poison value whenever the address, width or select has been stable for fewer cycles than the data sheet waits demand. Any early sample therefore shows up as a data mismatch, in addition to the direct cycle-spacing checks.

// File: rtl/pagerom_pkg.sv
`timescale 1ns/1ps
package pagerom_pkg;

    typedef enum logic [1:0] {
        OE_ACT_LOW  = 2'd0,
        OE_ACT_HIGH = 2'd1,
        OE_NONE     = 2'd2
    } oe_mode_e;

    typedef enum logic [1:0] {
        ST_PWRUP  = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_FLOAT  = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic valid;
        logic done;
        logic err;
    } beat_flags_t;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
        return (ns + per_ns - 1) / per_ns;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pagerom_timer.sv
`timescale 1ns/1ps
module pagerom_timer #(
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned RST_VAL = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R4/R5: an expired count without reload stays expired (no wrap)
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/pagerom_loc_seq.sv
`timescale 1ns/1ps
module pagerom_loc_seq #(
    parameter int unsigned ADDR_W    = 23,
    parameter int unsigned PAGE_LOG2 = 2
) (
    input  logic            byte_mode,
    input  logic [ADDR_W:0] loc,
    output logic [ADDR_W:0] next_loc,
    output logic            page_cross,
    output logic            at_end
);
    localparam int unsigned LOC_W = ADDR_W + 1;
    localparam logic [LOC_W-1:0] WORD_PMASK = LOC_W'((1 << PAGE_LOG2) - 1);
    localparam logic [LOC_W-1:0] BYTE_PMASK = LOC_W'((1 << (PAGE_LOG2 + 1)) - 1);

    logic [LOC_W-1:0] pmask;

    always_comb begin
        pmask      = byte_mode ? BYTE_PMASK : WORD_PMASK;
        next_loc   = loc + 1'b1;
        page_cross = ((next_loc & pmask) == '0);
        at_end     = byte_mode ? (&loc) : (&loc[ADDR_W-1:0]);
    end

endmodule

// File: rtl/pagerom_pins.sv
`timescale 1ns/1ps
module pagerom_pins import pagerom_pkg::*; #(
    parameter int unsigned ADDR_W  = 23,
    parameter oe_mode_e    OE_MODE = OE_ACT_LOW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_on,
    input  logic              byte_mode,
    input  logic [ADDR_W:0]   loc,
    input  logic [15:0]       rom_dq,
    output logic              rom_ce_n,
    output logic              rom_oe,
    output logic              rom_wide,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_lsb_out,
    output logic              rom_lsb_oe,
    output logic [15:0]       cap_data
);
    localparam logic OE_IDLE = (OE_MODE == OE_ACT_LOW) ? 1'b1 : 1'b0;

    assign rom_ce_n    = !ce_on;
    assign rom_wide    = !byte_mode;
    assign rom_addr    = byte_mode ? loc[ADDR_W:1] : loc[ADDR_W-1:0];
    assign rom_lsb_out = byte_mode & loc[0];
    assign rom_lsb_oe  = byte_mode;
    assign cap_data    = byte_mode ? {8'h00, rom_dq[7:0]} : rom_dq;

    generate
        if (OE_MODE == OE_ACT_LOW) begin : g_oe_low
            assign rom_oe = !ce_on;
        end else if (OE_MODE == OE_ACT_HIGH) begin : g_oe_high
            assign rom_oe = ce_on;
        end else begin : g_oe_none
            assign rom_oe = 1'b0;
        end
    endgenerate

    // R11: output enable rests at its idle level whenever the chip is deselected
    a_r11_oe_idle: assert property (@(posedge clk) disable iff (rst)
        rom_ce_n |-> (rom_oe == OE_IDLE));

    // R7: in 8-bit operation the shared top pin is driven as an address input
    a_r7_lsb_driven: assert property (@(posedge clk) disable iff (rst)
        (!rom_ce_n && !rom_wide) |-> rom_lsb_oe);

endmodule

// File: rtl/pagerom_rd_ctrl.sv
`timescale 1ns/1ps
module pagerom_rd_ctrl import pagerom_pkg::*; #(
    parameter int unsigned ADDR_W      = 23,
    parameter int unsigned LEN_W       = 8,
    parameter int unsigned PAGE_LOG2   = 2,
    parameter int unsigned CLK_NS      = 5,
    parameter int unsigned T_ACC_NS    = 120,
    parameter int unsigned T_PAGE_NS   = 25,
    parameter int unsigned T_FLOAT_NS  = 20,
    parameter int unsigned T_PWRUP_NS  = 200,
    parameter oe_mode_e    OE_MODE     = OE_ACT_LOW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_byte_mode,
    input  logic [ADDR_W:0]   req_loc,
    input  logic [LEN_W-1:0]  req_len_m1,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              rd_done,
    output logic              rd_err,
    output logic              rom_ce_n,
    output logic              rom_oe,
    output logic              rom_wide,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_lsb_out,
    output logic              rom_lsb_oe,
    input  logic [15:0]       rom_dq
);
    localparam int unsigned ACC_CYC  = ns_to_cyc(T_ACC_NS,   CLK_NS);
    localparam int unsigned PAGE_CYC = ns_to_cyc(T_PAGE_NS,  CLK_NS);
    localparam int unsigned FLT_CYC  = ns_to_cyc(T_FLOAT_NS, CLK_NS);
    localparam int unsigned PWR_CYC  = ns_to_cyc(T_PWRUP_NS, CLK_NS);
    localparam int unsigned MAX_CYC  = max2(max2(ACC_CYC, PAGE_CYC), max2(FLT_CYC, PWR_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    rd_state_e        state;
    logic [ADDR_W:0]  loc;
    logic             byte_q;
    logic [LEN_W-1:0] remaining;
    beat_flags_t      flags;

    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_zero;
    logic [ADDR_W:0]  next_loc;
    logic             page_cross;
    logic             at_end;
    logic [15:0]      cap_data;
    logic             ce_on;
    logic             last_beat;

    pagerom_timer #(.CNT_W(CNT_W), .RST_VAL(PWR_CYC)) i_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_zero)
    );

    pagerom_loc_seq #(.ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2)) i_seq (
        .byte_mode(byte_q), .loc(loc), .next_loc(next_loc),
        .page_cross(page_cross), .at_end(at_end)
    );

    pagerom_pins #(.ADDR_W(ADDR_W), .OE_MODE(OE_MODE)) i_pins (
        .clk(clk), .rst(rst), .ce_on(ce_on), .byte_mode(byte_q), .loc(loc),
        .rom_dq(rom_dq), .rom_ce_n(rom_ce_n), .rom_oe(rom_oe), .rom_wide(rom_wide),
        .rom_addr(rom_addr), .rom_lsb_out(rom_lsb_out), .rom_lsb_oe(rom_lsb_oe),
        .cap_data(cap_data)
    );

    assign ce_on     = (state == ST_ACCESS);
    assign req_ready = (state == ST_IDLE);
    assign last_beat = (remaining == '0) || at_end;

    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        if (state == ST_IDLE && req_valid) begin
            t_load = 1'b1;
            t_val  = CNT_W'(ACC_CYC);
        end else if (state == ST_ACCESS && t_zero) begin
            t_load = 1'b1;
            if (last_beat)       t_val = CNT_W'(FLT_CYC);
            else if (page_cross) t_val = CNT_W'(ACC_CYC);
            else                 t_val = CNT_W'(PAGE_CYC);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PWRUP;
            loc       <= '0;
            byte_q    <= 1'b0;
            remaining <= '0;
            flags     <= '0;
            rd_data   <= '0;
        end else begin
            flags <= '0;
            case (state)
                ST_PWRUP: if (t_zero) state <= ST_IDLE;
                ST_IDLE: begin
                    if (req_valid) begin
                        state     <= ST_ACCESS;
                        byte_q    <= req_byte_mode;
                        loc       <= req_byte_mode ? req_loc : {1'b0, req_loc[ADDR_W-1:0]};
                        remaining <= req_len_m1;
                    end
                end
                ST_ACCESS: begin
                    if (t_zero) begin
                        flags.valid <= 1'b1;
                        rd_data     <= cap_data;
                        if (last_beat) begin
                            flags.done <= 1'b1;
                            flags.err  <= (remaining != '0);
                            state      <= ST_FLOAT;
                        end else begin
                            loc       <= next_loc;
                            remaining <= remaining - 1'b1;
                        end
                    end
                end
                ST_FLOAT: if (t_zero) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign rd_valid = flags.valid;
    assign rd_done  = flags.done;
    assign rd_err   = flags.err;

    // R1: settling period keeps the ROM deselected and the request port closed
    a_r1_pwrup_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWRUP) |-> (rom_ce_n && !req_ready));

    // R2: the controller only offers to take a request while the ROM is deselected
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> rom_ce_n);

    // R8: burst completion coincides with a returned item
    a_r8_done_with_data: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> rd_valid);

    // R9: the overrun flag only accompanies burst completion
    a_r9_err_at_done: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> rd_done);

    // R12: width select is frozen while the chip is selected
    a_r12_width_steady: assert property (@(posedge clk) disable iff (rst)
        (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_wide));

endmodule

// File: tb/test_pagerom_rd_ctrl.sv
`timescale 1ns/1ps
module test_pagerom_rd_ctrl;
    import pagerom_pkg::*;

    localparam int AW   = 5;
    localparam int LW   = 8;
    localparam int PL   = 2;
    localparam int ACC  = 24;
    localparam int PAGE = 5;
    localparam int FLT  = 4;
    localparam int PWR  = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_byte_mode = 1'b0;
    logic [AW:0]   req_loc = '0;
    logic [LW-1:0] req_len_m1 = '0;
    logic          rd_valid, rd_done, rd_err;
    logic [15:0]   rd_data;
    logic          rom_ce_n, rom_oe, rom_wide, rom_lsb_out, rom_lsb_oe;
    logic [AW-1:0] rom_addr;
    logic [15:0]   rom_dq;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    pagerom_rd_ctrl #(
        .ADDR_W(AW), .LEN_W(LW), .PAGE_LOG2(PL), .CLK_NS(5),
        .T_ACC_NS(120), .T_PAGE_NS(25), .T_FLOAT_NS(20), .T_PWRUP_NS(200),
        .OE_MODE(OE_ACT_HIGH)
    ) i_pagerom_rd_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_byte_mode(req_byte_mode), .req_loc(req_loc), .req_len_m1(req_len_m1),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done), .rd_err(rd_err),
        .rom_ce_n(rom_ce_n), .rom_oe(rom_oe), .rom_wide(rom_wide), .rom_addr(rom_addr),
        .rom_lsb_out(rom_lsb_out), .rom_lsb_oe(rom_lsb_oe), .rom_dq(rom_dq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] wfun(input int w);
        return 16'((w * 1237 + 16'h3C1B) ^ (w << 7));
    endfunction

    function automatic logic [7:0] bfun(input int b);
        logic [15:0] w;
        w = wfun(b >> 1);
        return b[0] ? w[15:8] : w[7:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ROM model: data is valid only after the required stable times
    logic [AW-1:0] p_addr = '0;
    logic          p_lsb = 1'b0, p_wide = 1'b1, p_on = 1'b0;
    int            st_full = 0, st_page = 0;
    wire           rom_on = !rom_ce_n && rom_oe;

    always @(negedge clk) begin
        if (!rom_on || !p_on || rom_wide != p_wide || (rom_addr >> PL) != (p_addr >> PL))
            st_full <= 0;
        else if (st_full < 1000)
            st_full <= st_full + 1;
        if (rom_addr != p_addr || (!rom_wide && rom_lsb_out != p_lsb))
            st_page <= 0;
        else if (st_page < 1000)
            st_page <= st_page + 1;
        p_addr <= rom_addr;
        p_lsb  <= rom_lsb_out;
        p_wide <= rom_wide;
        p_on   <= rom_on;
    end

    always_comb begin
        if (rom_on && st_full >= ACC && st_page >= PAGE) begin
            if (rom_wide) rom_dq = wfun(int'(rom_addr));
            else          rom_dq = {rom_lsb_out, 7'h55, bfun(int'({rom_addr, rom_lsb_out}))};
        end else begin
            rom_dq = {(rom_wide ? 1'b1 : rom_lsb_out), 15'h5BAD};
        end
    end

    // chip-select idle-run monitor: R1 for the first selection, R10 afterwards
    int hi_run = 0;
    bit first_sel = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (rom_ce_n) hi_run <= hi_run + 1;
            else begin
                if (hi_run > 0) begin
                    if (first_sel) check(hi_run >= PWR, "R1 settle cycles", hi_run, PWR);
                    else           check(hi_run >= FLT, "R10 release cycles", hi_run, FLT);
                    first_sel <= 1'b0;
                end
                hi_run <= 0;
            end
        end
    end

    task automatic run(input bit bm, input int start, input int lenm1);
        int last, avail, n, got, t_prev, loc, gap, exp_gap, pmask;
        bit exp_err;
        last    = bm ? (1 << (AW + 1)) - 1 : (1 << AW) - 1;
        pmask   = bm ? (1 << (PL + 1)) - 1 : (1 << PL) - 1;
        avail   = last - start + 1;
        n       = (lenm1 + 1 < avail) ? lenm1 + 1 : avail;
        exp_err = (lenm1 + 1 > avail);
        got     = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid     = 1'b1;
        req_byte_mode = bm;
        req_loc       = (AW+1)'(start);
        req_len_m1    = LW'(lenm1);
        t_prev        = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready && !rom_ce_n, "R2 accepted and selected", {req_ready, rom_ce_n}, 0);
        check(rom_oe == 1'b1, "R11 oe active while selected", rom_oe, 1);
        if (bm) begin
            check(rom_addr == AW'(start >> 1) && rom_lsb_out == start[0] && rom_lsb_oe && !rom_wide,
                  "R7 byte pin mapping", {rom_addr, rom_lsb_out, rom_lsb_oe, rom_wide},
                  {AW'(start >> 1), start[0], 1'b1, 1'b0});
        end else begin
            check(rom_addr == AW'(start) && !rom_lsb_oe && rom_wide,
                  "R6 word pin mapping", {rom_addr, rom_lsb_oe, rom_wide}, {AW'(start), 1'b0, 1'b1});
        end
        while (got < n) begin
            if (rd_valid) begin
                loc = start + got;
                gap = cyc - t_prev;
                if (got == 0) begin
                    exp_gap = ACC + 2;
                    check(gap == exp_gap, "R3 first item latency", gap, exp_gap);
                end else if ((loc & pmask) == 0) begin
                    exp_gap = ACC + 1;
                    check(gap == exp_gap, "R5 page crossing spacing", gap, exp_gap);
                end else begin
                    exp_gap = PAGE + 1;
                    check(gap == exp_gap, "R4 in-page spacing", gap, exp_gap);
                end
                if (bm) check(rd_data == {8'h00, bfun(loc)}, "R7 byte data", rd_data, {8'h00, bfun(loc)});
                else    check(rd_data == wfun(loc), "R6 word data", rd_data, wfun(loc));
                check(rd_done == (got == n - 1), "R8 done placement", rd_done, (got == n - 1));
                if (got == n - 1) check(rd_err == exp_err, "R9 overrun flag", rd_err, exp_err);
                got++;
                t_prev = cyc;
            end
            @(negedge clk);
        end
        check(!rd_valid && rom_ce_n && !rom_oe, "R8 burst ends, R11 oe idle",
              {rd_valid, rom_ce_n, rom_oe}, 3'b010);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rom_ce_n && !req_ready && !rd_valid && !rom_oe, "R1 reset state",
              {rom_ce_n, req_ready, rd_valid, rom_oe}, 4'b1000);
        rst = 1'b0;
        repeat (PWR / 2) @(negedge clk);
        check(rom_ce_n && !req_ready, "R1 held during settle", {rom_ce_n, req_ready}, 2'b10);

        run(1'b0, 0, 31);                        // every word, 8 pages
        run(1'b1, 0, 63);                        // every byte, 8 pages
        for (int s = 0; s < 8; s++)  run(1'b0, s, 2);
        for (int s = 0; s < 16; s++) run(1'b1, s, 3);
        run(1'b0, 30, 4);                        // R9 word overrun
        run(1'b0, 31, 0);                        // last word exactly
        run(1'b1, 61, 2);                        // ends on last byte, no error
        run(1'b1, 62, 3);                        // R9 byte overrun
        run(1'b0, 3, 0);                         // single word after byte burst (R12 width switch)

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule